// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This engine performs the SHA-256 compression step for one 512-bit block. The caller supplies the already-expanded message schedule, one 32-bit word per handshake, in schedule order. A start strobe loads a 256-bit chaining value. The engine runs the 64 rounds on eight 32-bit working words. It then adds the final working state into the chaining value and presents the sum as the digest, together with a one-cycle done pulse. Padding and message expansion are done outside the engine. For a multi-block message, the caller feeds each digest back in as the chaining value of the next block.

The round loop is retimed. The sum of the upcoming round's H word, its round constant and its message word is formed one cycle ahead and held in a register. The constant is also read from its table into a register a further cycle ahead. The round itself then reduces its operands through carry-save stages into a single carry-propagate adder for each new word. When the schedule word is present on every cycle it is requested, a block takes 68 clock edges from start to done.

Top module: `sha256_retimed_core`

## Requirements
- R1: While reset is high and after reset is released, `done` and `wReady` are low and `digest` is all zeros until the first block completes.
- R2: After a block completes, `digest` equals the standard SHA-256 compression of `hashIn` with the 64 supplied schedule words, added word-wise modulo 2^32 to `hashIn`. Working word A sits in bits [255:224] and H in bits [31:0] of both `hashIn` and `digest`.
- R3: When `wValid` is high on every cycle `wReady` is high, `done` is high in the cycle after the 68th rising edge that follows the edge sampling `start`.
- R4: `wReady` is first high two edges after the start edge. Exactly 64 words are accepted per block (an accept is `wValid` and `wReady` high at the same edge). `wReady` is low while idle.
- R5: A cycle with `wReady` high and `wValid` low accepts nothing and advances nothing. The digest is unchanged by such stalls, and `done` is delayed by exactly one cycle for each stall.
- R6: `start` is ignored while a block is in progress. The block in flight finishes with its original chaining value.
- R7: `done` is high for a single cycle. `digest` holds its value until the next block completes.
- R8: A block started with `hashIn` equal to the previous digest continues a multi-block message correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a block; sampled only while idle |
| hashIn | input | 256 | Chaining value A..H, A in the top word |
| wData | input | 32 | Next expanded schedule word |
| wValid | input | 1 | `wData` is valid |
| wReady | output | 1 | Engine takes a word at this edge if `wValid` |
| digest | output | 256 | Chaining value plus final working state |
| done | output | 1 | One-cycle pulse: `digest` just updated |

## Verification
The bench runs known single-block and two-block messages. A wrong rotation, constant, function, or skew between the pre-added H+K+W value and the round it feeds would show up as a wrong digest. It measures the exact start-to-done edge count, which catches a missing or extra pipeline cycle. It inserts pseudo-random gaps in the word stream: a design that advanced its round counter or constant register without a word would corrupt the digest or finish early. It also pulses `start` mid-block, where a design that reloaded the chaining value would produce a different hash. Finally, it asserts reset in the middle of a block.

// File: rtl/sha256_core_pkg.sv
package sha256_core_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_WORDS  = 8;
  localparam int unsigned N_ROUNDS = 64;
  localparam int unsigned RND_W    = $clog2(N_ROUNDS);
  localparam int unsigned DIG_W    = WORD_W * N_WORDS;

  // working word slots; A is the most significant word of the packed value
  localparam int unsigned IDX_A = 7;
  localparam int unsigned IDX_B = 6;
  localparam int unsigned IDX_C = 5;
  localparam int unsigned IDX_E = 3;
  localparam int unsigned IDX_F = 2;
  localparam int unsigned IDX_G = 1;
  localparam int unsigned IDX_H = 0;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t sum;
    word_t carry;
  } csa_t;

  typedef struct packed {
    logic             loadChain;
    logic             initWork;
    logic             kLoad;
    logic [RND_W-1:0] kIdx;
    logic             preAdd;
    logic             preUseG;
    logic             doRound;
    logic             finalSum;
    logic             outLatch;
  } ctrl_strobe_t;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t chooseF(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majF(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic csa_t csa3(input word_t x, input word_t y, input word_t z);
    csa_t r;
    r.sum   = x ^ y ^ z;
    r.carry = ((x & y) | (x & z) | (y & z)) << 1;
    return r;
  endfunction

  function automatic word_t roundK(input logic [RND_W-1:0] idx);
    word_t k;
    k = '0;
    case (idx)
      6'd0:  k = 32'h428a2f98;
      6'd1:  k = 32'h71374491;
      6'd2:  k = 32'hb5c0fbcf;
      6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b;
      6'd5:  k = 32'h59f111f1;
      6'd6:  k = 32'h923f82a4;
      6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98;
      6'd9:  k = 32'h12835b01;
      6'd10: k = 32'h243185be;
      6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74;
      6'd13: k = 32'h80deb1fe;
      6'd14: k = 32'h9bdc06a7;
      6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1;
      6'd17: k = 32'hefbe4786;
      6'd18: k = 32'h0fc19dc6;
      6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f;
      6'd21: k = 32'h4a7484aa;
      6'd22: k = 32'h5cb0a9dc;
      6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152;
      6'd25: k = 32'ha831c66d;
      6'd26: k = 32'hb00327c8;
      6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3;
      6'd29: k = 32'hd5a79147;
      6'd30: k = 32'h06ca6351;
      6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85;
      6'd33: k = 32'h2e1b2138;
      6'd34: k = 32'h4d2c6dfc;
      6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354;
      6'd37: k = 32'h766a0abb;
      6'd38: k = 32'h81c2c92e;
      6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1;
      6'd41: k = 32'ha81a664b;
      6'd42: k = 32'hc24b8b70;
      6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819;
      6'd45: k = 32'hd6990624;
      6'd46: k = 32'hf40e3585;
      6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116;
      6'd49: k = 32'h1e376c08;
      6'd50: k = 32'h2748774c;
      6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3;
      6'd53: k = 32'h4ed8aa4a;
      6'd54: k = 32'h5b9cca4f;
      6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee;
      6'd57: k = 32'h78a5636f;
      6'd58: k = 32'h84c87814;
      6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa;
      6'd61: k = 32'ha4506ceb;
      6'd62: k = 32'hbef9a3f7;
      6'd63: k = 32'hc67178f2;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sha256_core_ctrl.sv
module sha256_core_ctrl
  import sha256_core_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         wValid,
  output logic         wReady,
  output ctrl_strobe_t st,
  output logic         done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_PRE, ST_ROUND, ST_FINAL, ST_OUT
  } state_t;

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);

  state_t           stateQ, stateD;
  logic [RND_W-1:0] rndQ, rndD;
  logic             doneQ;
  logic [RND_W:0]   wordCnt;

  always_comb begin
    stateD = stateQ;
    rndD   = rndQ;
    wReady = 1'b0;
    st     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          st.loadChain = 1'b1;
          stateD       = ST_INIT;
        end
      end
      ST_INIT: begin
        st.initWork = 1'b1;
        st.kLoad    = 1'b1;
        st.kIdx     = '0;
        stateD      = ST_PRE;
      end
      ST_PRE: begin
        wReady = 1'b1;
        if (wValid) begin
          st.preAdd = 1'b1;
          st.kLoad  = 1'b1;
          st.kIdx   = RND_W'(1);
          rndD      = '0;
          stateD    = ST_ROUND;
        end
      end
      ST_ROUND: begin
        if (rndQ == LAST_RND) begin
          st.doRound = 1'b1;
          stateD     = ST_FINAL;
        end else begin
          wReady = 1'b1;
          if (wValid) begin
            st.doRound = 1'b1;
            st.preAdd  = 1'b1;
            st.preUseG = 1'b1;
            st.kLoad   = 1'b1;
            st.kIdx    = rndQ + RND_W'(2);
            rndD       = rndQ + RND_W'(1);
          end
        end
      end
      ST_FINAL: begin
        st.finalSum = 1'b1;
        stateD      = ST_OUT;
      end
      ST_OUT: begin
        st.outLatch = 1'b1;
        stateD      = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      rndQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      rndQ   <= rndD;
      doneQ  <= st.outLatch;
    end
  end

  // words accepted since the current block was started
  always_ff @(posedge clk) begin
    if (rst || st.loadChain) wordCnt <= '0;
    else if (wValid && wReady) wordCnt <= wordCnt + 1'b1;
  end

  assign done = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_STALL_HOLDS_ROUND: assert property (@(posedge clk) disable iff (rst)
    (wReady && !wValid) |=> $stable(rndQ)); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && stateQ != ST_IDLE) |=> (stateQ != ST_INIT)); // R6

  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (rst)
    st.outLatch |-> (wordCnt == (RND_W+1)'(N_ROUNDS))); // R4

endmodule

// File: rtl/sha256_core_dp.sv
module sha256_core_dp
  import sha256_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_strobe_t     st,
  input  logic [DIG_W-1:0] hashIn,
  input  word_t            wData,
  output logic [DIG_W-1:0] digest
);

  word_t            chainQ [N_WORDS];
  word_t            workQ  [N_WORDS];
  word_t            sumW   [N_WORDS];
  word_t            hkwQ;
  word_t            kReg;
  logic [DIG_W-1:0] digestQ;

  word_t s0, s1, chv, mjv, hSrc, aN, eN, preN;
  csa_t  cT1, cE, cA1, cA2, cPre;

  // round logic: hkwQ already carries H + K + W for this round
  always_comb begin
    s1   = bigSig1(workQ[IDX_E]);
    chv  = chooseF(workQ[IDX_E], workQ[IDX_F], workQ[IDX_G]);
    s0   = bigSig0(workQ[IDX_A]);
    mjv  = majF(workQ[IDX_A], workQ[IDX_B], workQ[IDX_C]);
    cT1  = csa3(hkwQ, s1, chv);
    cE   = csa3(cT1.sum, cT1.carry, workQ[IDX_E + 1]);
    eN   = cE.sum + cE.carry;
    cA1  = csa3(cT1.sum, cT1.carry, s0);
    cA2  = csa3(cA1.sum, cA1.carry, mjv);
    aN   = cA2.sum + cA2.carry;
    // next round's H is the present G, except before the first round
    hSrc = st.preUseG ? workQ[IDX_G] : workQ[IDX_H];
    cPre = csa3(hSrc, kReg, wData);
    preN = cPre.sum + cPre.carry;
  end

  for (genvar i = 0; i < N_WORDS; i++) begin : g_final
    assign sumW[i] = chainQ[i] + workQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_WORDS; i++) begin
        chainQ[i] <= '0;
        workQ[i]  <= '0;
      end
      hkwQ    <= '0;
      kReg    <= '0;
      digestQ <= '0;
    end else begin
      if (st.loadChain)
        for (int i = 0; i < N_WORDS; i++) chainQ[i] <= hashIn[i*WORD_W +: WORD_W];
      if (st.finalSum)
        for (int i = 0; i < N_WORDS; i++) chainQ[i] <= sumW[i];
      if (st.initWork)
        for (int i = 0; i < N_WORDS; i++) workQ[i] <= chainQ[i];
      if (st.doRound) begin
        for (int i = 0; i < N_WORDS - 1; i++) workQ[i] <= workQ[i+1];
        workQ[IDX_E] <= eN;
        workQ[IDX_A] <= aN;
      end
      if (st.kLoad)  kReg <= roundK(st.kIdx);
      if (st.preAdd) hkwQ <= preN;
      if (st.outLatch)
        for (int i = 0; i < N_WORDS; i++) digestQ[i*WORD_W +: WORD_W] <= chainQ[i];
    end
  end

  assign digest = digestQ;

  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !st.outLatch |=> $stable(digest)); // R7

  AST_CHAIN_FROZEN_IN_ROUNDS: assert property (@(posedge clk) disable iff (rst)
    st.doRound |=> $stable(sumW[IDX_H] - workQ[IDX_H])); // R6

endmodule

// File: rtl/sha256_retimed_core.sv
module sha256_retimed_core
  import sha256_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIG_W-1:0] hashIn,
  input  logic [WORD_W-1:0] wData,
  input  logic             wValid,
  output logic             wReady,
  output logic [DIG_W-1:0] digest,
  output logic             done
);

  ctrl_strobe_t strobes;

  sha256_core_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .wValid (wValid),
    .wReady (wReady),
    .st     (strobes),
    .done   (done)
  );

  sha256_core_dp dp_i (
    .clk    (clk),
    .rst    (rst),
    .st     (strobes),
    .hashIn (hashIn),
    .wData  (wData),
    .digest (digest)
  );

endmodule

// File: tb/sha256_retimed_core_tb_top.sv
`timescale 1ns/1ps
module sha256_retimed_core_tb_top;

  localparam int NVEC = 4;
  localparam int LAT  = 68;
  localparam logic [255:0] IV =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

  localparam logic [511:0] VEC_BLK [NVEC] = '{
    512'h61626380_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000018,
    512'h80000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000,
    512'h61626364_62636465_63646566_64656667_65666768_66676869_6768696a_68696a6b_696a6b6c_6a6b6c6d_6b6c6d6e_6c6d6e6f_6d6e6f70_6e6f7071_80000000_00000000,
    512'h00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_00000000_000001c0
  };
  localparam logic [255:0] VEC_EXP [NVEC] = '{
    256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad,
    256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855,
    256'h0,
    256'h248d6a61_d20638b8_e5c02693_0c3e6039_a33ce459_64ff2167_f6ecedd4_19db06c1
  };
  // per vector flags: chain from previous digest, check digest, stall, poke start
  localparam logic [3:0] VEC_FLG [NVEC] = '{4'b0100, 4'b0101, 4'b0000, 4'b1110};

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [255:0] hashIn;
  logic [31:0]  wData;
  logic         wValid;
  logic         wReady;
  logic [255:0] digest;
  logic         done;

  int errors = 0;
  int checks = 0;
  int totalCyc = 0;

  logic [31:0]  wSched [64];
  logic [255:0] gotDigest;
  int           gotLat;
  int           gotWords;
  int           gotStalls;

  sha256_retimed_core dut_i (
    .clk(clk), .rst(rst), .start(start), .hashIn(hashIn),
    .wData(wData), .wValid(wValid), .wReady(wReady),
    .digest(digest), .done(done)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    totalCyc++;
    if (totalCyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", totalCyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic expand(input logic [511:0] blk);
    for (int t = 0; t < 16; t++) wSched[t] = blk[511 - 32*t -: 32];
    for (int t = 16; t < 64; t++)
      wSched[t] = (rr(wSched[t-2], 17) ^ rr(wSched[t-2], 19) ^ (wSched[t-2] >> 10))
                + wSched[t-7]
                + (rr(wSched[t-15], 7) ^ rr(wSched[t-15], 18) ^ (wSched[t-15] >> 3))
                + wSched[t-16];
  endtask

  task automatic runBlock(input logic [255:0] hv, input logic [511:0] blk,
                          input bit stall, input bit poke);
    int   cyc;
    int   wIdx;
    int   stalls;
    bit   fin;
    logic acc;
    logic [7:0] lf;
    lf = 8'h5a;
    expand(blk);
    @(negedge clk);
    start = 1'b1; hashIn = hv; wValid = 1'b0;
    @(posedge clk);
    cyc = 0; wIdx = 0; stalls = 0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && cyc == 20) begin start = 1'b1; hashIn = ~hv; end
      if (done || cyc > 2000) fin = 1'b1;
      else begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        wValid = (wIdx < 64) && (!stall || lf[0]);
        wData  = (wIdx < 64) ? wSched[wIdx] : 32'h0;
        if (wReady && !wValid && wIdx < 64) stalls++;
        acc = wValid && wReady;
        @(posedge clk);
        cyc++;
        if (acc) wIdx++;
      end
    end
    wValid = 1'b0;
    gotDigest = digest;
    gotLat    = cyc;
    gotWords  = wIdx;
    gotStalls = stalls;
  endtask

  initial begin
    logic [255:0] prevDig;
    logic [255:0] hv;
    logic [255:0] held;
    rst = 1'b1; start = 1'b0; hashIn = '0; wData = '0; wValid = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", {255'b0, done}, 256'h0);
    check(wReady == 1'b0, "R1 wReady in reset", {255'b0, wReady}, 256'h0);
    rst = 1'b0;
    @(negedge clk);
    check(digest == '0, "R1 digest after reset", digest, 256'h0);
    check(wReady == 1'b0, "R4 wReady idle", {255'b0, wReady}, 256'h0);

    prevDig = IV;
    for (int v = 0; v < NVEC; v++) begin
      hv = VEC_FLG[v][3] ? prevDig : IV;
      runBlock(hv, VEC_BLK[v], VEC_FLG[v][1], VEC_FLG[v][0]);
      if (VEC_FLG[v][2])
        check(gotDigest == VEC_EXP[v],
              VEC_FLG[v][3] ? "R8 chained digest" :
              (VEC_FLG[v][0] ? "R6 digest with start poke" : "R2 digest"),
              gotDigest, VEC_EXP[v]);
      if (VEC_FLG[v][1]) begin
        check(gotStalls > 0, "R5 stalls inserted", gotStalls, 1);
        check(gotLat == LAT + gotStalls, "R5 stalled latency", gotLat, LAT + gotStalls);
      end else
        check(gotLat == LAT, "R3 latency", gotLat, LAT);
      check(gotWords == 64, "R4 word count", gotWords, 64);
      held = gotDigest;
      @(negedge clk);
      check(done == 1'b0, "R7 done pulse width", {255'b0, done}, 256'h0);
      repeat (3) @(negedge clk);
      check(digest == held, "R7 digest held", digest, held);
      check(wReady == 1'b0, "R4 wReady idle after block", {255'b0, wReady}, 256'h0);
      prevDig = gotDigest;
    end

    // reset in the middle of a block
    expand(VEC_BLK[0]);
    @(negedge clk);
    start = 1'b1; hashIn = IV; wValid = 1'b1; wData = wSched[0];
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    wValid = 1'b0;
    @(negedge clk);
    check(wReady == 1'b0, "R1 wReady after mid-block reset", {255'b0, wReady}, 256'h0);
    check(done == 1'b0, "R1 done after mid-block reset", {255'b0, done}, 256'h0);
    rst = 1'b0;
    @(negedge clk);
    check(digest == '0, "R1 digest cleared by reset", digest, 256'h0);
    runBlock(IV, VEC_BLK[0], 1'b1, 1'b0);
    check(gotDigest == VEC_EXP[0], "R2 digest after reset, stalled", gotDigest, VEC_EXP[0]);
    check(gotLat == LAT + gotStalls, "R5 latency after reset", gotLat, LAT + gotStalls);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule